// File: doc/BRIEF.md
# Shared-Adder Signed ALU

This block is a purely combinational arithmetic and logic unit for two small two's-complement operands. A three-bit function code selects one of six operations: addition, subtraction, bitwise exclusive-or, exclusive-or against the inverted second operand, a less-than flag and an equality flag. The result is four bits wide and appears in the same cycle as the inputs, so the surrounding logic registers it wherever it needs to.

All arithmetic runs through one ripple adder. The top function bit turns on the subtract path. With that bit set, the second operand is inverted on its way into the adder and the carry-in is driven high. The low two function bits steer a single four-way result selector. Its inputs are the adder output, the bitwise result, the zero-widened top bit of the adder output, and the zero-widened equality flag.

The less-than flag is the raw sign bit of the wrapped difference, with no overflow correction. Callers that need a true signed comparison over the full range must not rely on it near the range ends.

Top module: `shared_adder_alu`

## Requirements
- R1: With function code 000, y_o equals (a_i + b_i) modulo 16.
- R2: With function code 001, y_o equals a_i XOR b_i, bit by bit.
- R3: With function code 100, y_o equals (a_i - b_i) modulo 16. This is formed as a_i + ~b_i + 1 in the same adder that R1 uses.
- R4: With function code 101, y_o equals a_i XOR (NOT b_i), which is the bitwise XNOR of the operands.
- R5: With function code 110, y_o[3:1] is 000 and y_o[0] is bit 3 of ((a_i - b_i) modulo 16). No overflow correction is applied. So a_i=0111 with b_i=1000 gives 0001, and a_i=1000 with b_i=0001 gives 0000.
- R6: With function code 111, y_o[3:1] is 000 and y_o[0] is 1 exactly when a_i equals b_i.
- R7: Function codes 010 and 011 are unused and drive y_o to 0000 for every operand pair.
- R8: y_o depends only on the present values of a_i, b_i and op_i. After any change of the inputs it shows the new result, with no dependence on earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand, two's complement |
| b_i | input | 4 | Second operand, two's complement |
| op_i | input | 3 | Function code; bit 2 selects subtract, bits 1:0 select the result |
| y_o | output | 4 | Selected result |

## Verification
The subtraction and the less-than flag both depend on the same adder in the same evaluation. A fault in the operand inversion or the carry-in therefore shows up in both at once. The bench applies codes 100 and 110 back to back on each operand pair. It judges the flag against bit 3 of a bench-computed wrapped difference, not against a true signed comparison, and includes the wrap pairs 0111/1000 and 1000/0001 where the two interpretations differ. Every code is swept over all 256 operand pairs, mixed with seeded random pairs.

// File: rtl/alu_pkg.sv
// Package: shared constants and types for the shared-adder ALU.
// Assumes the function code is three bits: bit 2 is the subtract enable,
// bits 1:0 pick the result source.
package alu_pkg;

    localparam int unsigned OP_W  = 3;
    localparam int unsigned SEL_W = 2;

    // Result source picked by the low two function bits.
    typedef enum logic [SEL_W-1:0] {
        SRC_SUM  = 2'b00,
        SRC_BITW = 2'b01,
        SRC_LESS = 2'b10,
        SRC_EQ   = 2'b11
    } res_src_t;

    // Decoded view of a function code.
    typedef struct packed {
        logic     sub_en;
        res_src_t src;
    } op_dec_t;

    // Split a raw function code into its fields.
    function automatic op_dec_t decode_op(input logic [OP_W-1:0] op);
        op_dec_t d;
        d.sub_en = op[2];
        d.src    = res_src_t'(op[1:0]);
        return d;
    endfunction

    // True for the unused function codes (subtract off and a flag source).
    function automatic logic op_unused(input logic [OP_W-1:0] op);
        return (op[2] == 1'b0) && (op[1] == 1'b1);
    endfunction

endpackage

// File: rtl/alu_operand_prep.sv
// Module: conditions the second operand for the shared adder.
// Passes the operand through unchanged and drives carry-in low for addition.
// For subtraction it inverts every bit and drives carry-in high.
// Assumes sub_en is stable for the whole evaluation (no clock here).
module alu_operand_prep #(
    parameter int unsigned W = 4
) (
    input  logic         sub_en,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         carry_in
);

    // Select the true or inverted operand and the matching carry-in.
    always_comb begin
        b_out    = sub_en ? ~b_in : b_in;
        carry_in = sub_en;
    end

endmodule

// File: rtl/alu_ripple_adder.sv
// Module: the single W-bit ripple-carry adder of the ALU.
// Each bit is a full adder cell built by a generate loop.
// Assumes operands are plain vectors; the signed meaning is left to callers.
module alu_ripple_adder #(
    parameter int unsigned W = 4
) (
    input  logic         [W-1:0] x_in,
    input  logic         [W-1:0] y_in,
    input  logic                 c_in,
    output logic         [W-1:0] sum,
    output logic                 c_out
);

    logic [W:0] carry;

    assign carry[0] = c_in;

    // One full adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_cell
        always_comb begin
            sum[i]     = x_in[i] ^ y_in[i] ^ carry[i];
            carry[i+1] = (x_in[i] & y_in[i]) | (carry[i] & (x_in[i] ^ y_in[i]));
        end
    end

    assign c_out = carry[W];

    // Check the ripple chain against a wide arithmetic sum (R1, R3).
    always_comb begin
        p_sum_r1: assert ({c_out, sum} == ({1'b0, x_in} + {1'b0, y_in} + {{W{1'b0}}, c_in}))
            else $error("ripple sum mismatch");
    end

endmodule

// File: rtl/alu_result_mux.sv
// Module: four-way result selector of the ALU.
// Outputs zero when the function code is one of the unused ones.
// Assumes every source is already W bits wide.
module alu_result_mux
    import alu_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  res_src_t     src,
    input  logic         force_zero,
    input  logic [W-1:0] sum_v,
    input  logic [W-1:0] bitw_v,
    input  logic [W-1:0] less_v,
    input  logic [W-1:0] eq_v,
    output logic [W-1:0] res
);

    // Pick the source named by the select, or zero for an unused code.
    always_comb begin
        unique case (src)
            SRC_SUM:  res = sum_v;
            SRC_BITW: res = bitw_v;
            SRC_LESS: res = less_v;
            SRC_EQ:   res = eq_v;
            default:  res = '0;
        endcase
        if (force_zero) res = '0;
    end

endmodule

// File: rtl/shared_adder_alu.sv
// Module: top of the combinational shared-adder ALU.
// Bit 2 of the function code turns on the subtract path into the one adder.
// Bits 1:0 choose sum, bitwise result, raw sign-bit less-than or equality.
// Assumes the caller registers the result; the block holds no state.
module shared_adder_alu
    import alu_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [OP_W-1:0] op_i,
    output logic [W-1:0]    y_o
);

    localparam int unsigned FLAG_PAD = W - 1;

    op_dec_t      dec;
    logic [W-1:0] b_cond;
    logic         cin;
    logic [W-1:0] adder_x;
    logic         adder_co;
    logic [W-1:0] bitw;
    logic [W-1:0] less_ext;
    logic [W-1:0] eq_ext;

    // Split the function code into its fields.
    always_comb dec = decode_op(op_i);

    alu_operand_prep #(.W(W)) i_prep (
        .sub_en   (dec.sub_en),
        .b_in     (b_i),
        .b_out    (b_cond),
        .carry_in (cin)
    );

    alu_ripple_adder #(.W(W)) i_adder (
        .x_in  (a_i),
        .y_in  (b_cond),
        .c_in  (cin),
        .sum   (adder_x),
        .c_out (adder_co)
    );

    // Bitwise result on the conditioned operand: XOR, or XNOR when inverted.
    always_comb bitw = a_i ^ b_cond;

    // Zero-widen the sign bit of the adder output and the equality flag.
    always_comb begin
        less_ext = {{FLAG_PAD{1'b0}}, adder_x[W-1]};
        eq_ext   = {{FLAG_PAD{1'b0}}, (a_i == b_i)};
    end

    alu_result_mux #(.W(W)) i_mux (
        .src        (dec.src),
        .force_zero (op_unused(op_i)),
        .sum_v      (adder_x),
        .bitw_v     (bitw),
        .less_v     (less_ext),
        .eq_v       (eq_ext),
        .res        (y_o)
    );

    // Port-level checks of the result against the operands.
    always_comb begin
        if (op_i == 3'b010 || op_i == 3'b011) begin
            p_unused_zero_r7: assert (y_o == '0) else $error("unused code not zero");
        end
        if (op_i == 3'b110) begin
            p_less_narrow_r5: assert (y_o[W-1:1] == '0) else $error("less flag not widened");
        end
        if (op_i == 3'b111) begin
            p_eq_flag_r6: assert (y_o == {{FLAG_PAD{1'b0}}, (a_i == b_i)}) else $error("eq flag wrong");
        end
        if (op_i == 3'b001) begin
            p_xor_r2: assert ((y_o ^ a_i) == b_i) else $error("xor wrong");
        end
        if (op_i == 3'b101) begin
            p_xnor_r4: assert ((y_o ^ a_i) == ~b_i) else $error("xnor wrong");
        end
    end

endmodule

// File: tb/test_shared_adder_alu.sv
// Bench: exhaustive sweep per function code, seeded random pairs, directed wraps.
module test_shared_adder_alu;

    logic       clk = 1'b0;
    logic [3:0] a, b, y;
    logic [2:0] op;
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    shared_adder_alu i_shared_adder_alu (
        .a_i  (a),
        .b_i  (b),
        .op_i (op),
        .y_o  (y)
    );

    // Expected result from the requirements, modulo 16.
    function automatic logic [3:0] expect_y(input logic [2:0] f, input logic [3:0] x, input logic [3:0] z);
        logic [3:0] d;
        d = 4'((int'(x) - int'(z)) & 15);
        case (f)
            3'b000: return 4'((int'(x) + int'(z)) & 15);
            3'b001: return x ^ z;
            3'b100: return d;
            3'b101: return ~(x ^ z);
            3'b110: return {3'b000, d[3]};
            3'b111: return {3'b000, x == z};
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] f);
        case (f)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b100: return "R3";
            3'b101: return "R4";
            3'b110: return "R5";
            3'b111: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string r, input logic [3:0] exp);
        total++;
        if (y !== exp) begin
            bad++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", r, op, a, b, y, exp);
        end
    endtask

    // Drive at a rising edge, sample at the following falling edge.
    task automatic apply(input logic [2:0] f, input logic [3:0] x, input logic [3:0] z, input string r);
        @(posedge clk);
        op = f; a = x; b = z;
        @(negedge clk);
        check(r, expect_y(f, x, z));
    endtask

    initial begin
        op = 3'b000; a = 4'h0; b = 4'h0;
        void'($urandom(32'd2024));
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 idle", 4'h0);

        // Directed wraps: raw sign bit, not true signed order (R5, R3).
        apply(3'b110, 4'h7, 4'h8, "R5 wrap high");
        check("R5 wrap high", 4'h1);
        apply(3'b110, 4'h8, 4'h1, "R5 wrap low");
        check("R5 wrap low", 4'h0);
        apply(3'b100, 4'h7, 4'h8, "R3 wrap");
        apply(3'b000, 4'h7, 4'h1, "R1 overflow");
        apply(3'b111, 4'h8, 4'h8, "R6 equal");
        apply(3'b011, 4'hF, 4'hF, "R7 unused");

        // Exhaustive sweep; subtract then less-than on the same pair.
        for (int pa = 0; pa < 16; pa++) begin
            for (int pb = 0; pb < 16; pb++) begin
                apply(3'b100, 4'(pa), 4'(pb), "R3");
                apply(3'b110, 4'(pa), 4'(pb), "R5");
                for (int f = 0; f < 8; f++) begin
                    if (f != 4 && f != 6) apply(3'(f), 4'(pa), 4'(pb), req_of(3'(f)));
                end
            end
        end

        // Seeded random pairs and codes; each checks the new inputs only (R8).
        for (int k = 0; k < 600; k++) begin
            logic [2:0] f;
            f = 3'($urandom);
            apply(f, 4'($urandom), 4'($urandom), $sformatf("R8 %s", req_of(f)));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule